// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block computes the address of the next instruction for a 32-bit instruction set. It takes the current program counter, the fetched instruction word and the two source register values that were read for it. It then produces the next program counter and a flag that says whether control flow was redirected. The block has no clock. Every output is a pure function of the present inputs, so it can sit in the same cycle as register read.

The block recognises a jump and six conditional branches. Two of the branches compare the two register operands with each other. The other four test the first operand, as a signed number, against zero. Two of those four share one opcode and are told apart by the second register field of the instruction. A branch offset counts instructions, not bytes, and is signed, so a loop can branch backwards. The jump keeps the top address bits of the sequential successor and replaces the rest with its own word index. Any other opcode lets execution fall through to the next word.

Top module: `npc_unit`

## Requirements
- R1: Opcode 4 (instruction bits 31:26) is taken exactly when `rs_val` equals `rt_val`.
- R2: Opcode 5 is taken exactly when `rs_val` differs from `rt_val`.
- R3: Opcode 6 is taken exactly when `rs_val`, read as two's complement, is zero or negative.
- R4: Opcode 7 is taken exactly when `rs_val`, read as two's complement, is strictly positive.
- R5: Opcode 1 uses the instruction's second register field (bits 20:16) to pick its test. A value of 0 is taken when `rs_val` is negative. A value of 1 is taken when `rs_val` is zero or positive. Any other value is never taken.
- R6: When a conditional branch is taken, `next_pc` is `cur_pc` + 4 + 4 × offset, where offset is bits 15:0 read as a signed number. When it is not taken, `next_pc` is `cur_pc` + 4. All sums wrap modulo 2^32.
- R7: Opcode 2 is always taken. Its target is bits 31:28 of `cur_pc` + 4, followed by instruction bits 25:0, followed by two zero bits.
- R8: Every opcode other than 1, 2, 4, 5, 6 and 7 gives `next_pc` = `cur_pc` + 4 with `taken` low.
- R9: `rt_val` has no effect on either output for opcodes 1, 2, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cur_pc | input | 32 | Address of the current instruction |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Value of the first source register |
| rt_val | input | 32 | Value of the second source register |
| next_pc | output | 32 | Address of the instruction to fetch next |
| taken | output | 1 | High when control flow is redirected |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-bit offset and a 26-bit jump index. At this size the interesting values can be swept. Each branch form is crossed with seven operand values: zero, ±1, ±5 and both signed extremes. Each combination is also tried with forward, backward and extreme offsets, and with a program counter near the point where adding four carries into the top four bits. Every opcode and every second-register-field value under opcode 1 is also swept, so that each opcode that falls through is shown to do so.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam logic [5:0] OPC_REGIMM = 6'd1;
  localparam logic [5:0] OPC_JUMP   = 6'd2;
  localparam logic [5:0] OPC_BEQ    = 6'd4;
  localparam logic [5:0] OPC_BNE    = 6'd5;
  localparam logic [5:0] OPC_BLEZ   = 6'd6;
  localparam logic [5:0] OPC_BGTZ   = 6'd7;

  localparam logic [4:0] SEL_LTZ    = 5'd0;
  localparam logic [4:0] SEL_GEZ    = 5'd1;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_EQ,
    FLOW_NE,
    FLOW_LEZ,
    FLOW_GTZ,
    FLOW_LTZ,
    FLOW_GEZ,
    FLOW_JUMP
  } flow_kind_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int INSN_W = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [INSN_W-1:0] instr,
  output flow_kind_e        kind,
  output logic [OFF_W-1:0]  offset,
  output logic [JIDX_W-1:0] jidx
);
  localparam int OP_LSB = INSN_W - OP_W;
  localparam int RS_LSB = OP_LSB - REG_W;
  localparam int RT_LSB = RS_LSB - REG_W;

  logic [OP_W-1:0]  opcode;
  logic [REG_W-1:0] sel;

  assign opcode = instr[INSN_W-1:OP_LSB];
  assign sel    = instr[RT_LSB +: REG_W];
  assign offset = instr[OFF_W-1:0];
  assign jidx   = instr[JIDX_W-1:0];

  always_comb begin
    kind = FLOW_SEQ;
    case (opcode)
      OPC_BEQ:  kind = FLOW_EQ;
      OPC_BNE:  kind = FLOW_NE;
      OPC_BLEZ: kind = FLOW_LEZ;
      OPC_BGTZ: kind = FLOW_GTZ;
      OPC_JUMP: kind = FLOW_JUMP;
      OPC_REGIMM: begin
        if (sel == SEL_LTZ)      kind = FLOW_LTZ;
        else if (sel == SEL_GEZ) kind = FLOW_GEZ;
        else                     kind = FLOW_SEQ;
      end
      default:  kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  flow_kind_e       kind,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic             take
);
  logic is_neg;
  logic is_zero;
  logic same;

  assign is_neg  = a[XLEN-1];
  assign is_zero = ~|a;
  assign same    = (a == b);

  always_comb begin
    case (kind)
      FLOW_EQ:   take = same;
      FLOW_NE:   take = ~same;
      FLOW_LEZ:  take = is_neg | is_zero;
      FLOW_GTZ:  take = ~is_neg & ~is_zero;
      FLOW_LTZ:  take = is_neg;
      FLOW_GEZ:  take = ~is_neg;
      FLOW_JUMP: take = 1'b1;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26,
  parameter int ALIGN  = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  flow_kind_e        kind,
  input  logic              take,
  input  logic [OFF_W-1:0]  offset,
  input  logic [JIDX_W-1:0] jidx,
  output logic [XLEN-1:0]   npc
);
  localparam int EXT_W    = XLEN - OFF_W - ALIGN;
  localparam int REGION_W = XLEN - JIDX_W - ALIGN;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN;

  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] disp;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] abs_pc;

  assign seq_pc = pc + STEP;
  assign disp   = {{EXT_W{offset[OFF_W-1]}}, offset, {ALIGN{1'b0}}};
  assign rel_pc = seq_pc + disp;

  generate
    if (REGION_W > 0) begin : g_region
      assign abs_pc = {seq_pc[XLEN-1 -: REGION_W], jidx, {ALIGN{1'b0}}};
    end else begin : g_flat
      assign abs_pc = {jidx, {ALIGN{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (!take)                  npc = seq_pc;
    else if (kind == FLOW_JUMP) npc = abs_pc;
    else                        npc = rel_pc;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int OFF_W  = 16,
  parameter int JIDX_W = 26
) (
  input  logic [31:0] cur_pc,
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] next_pc,
  output logic        taken
);
  flow_kind_e        kind;
  logic [OFF_W-1:0]  offset;
  logic [JIDX_W-1:0] jidx;
  logic              take;

  npc_decode #(.INSN_W(32), .OP_W(6), .REG_W(5), .OFF_W(OFF_W), .JIDX_W(JIDX_W)) u_dec (
    .instr  (instr),
    .kind   (kind),
    .offset (offset),
    .jidx   (jidx)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind (kind),
    .a    (rs_val),
    .b    (rt_val),
    .take (take)
  );

  npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JIDX_W(JIDX_W), .ALIGN(2)) u_tgt (
    .pc     (cur_pc),
    .kind   (kind),
    .take   (take),
    .offset (offset),
    .jidx   (jidx),
    .npc    (next_pc)
  );

  assign taken = take;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic [31:0] cur_pc,
  input logic [31:0] instr,
  input logic [31:0] rs_val,
  input logic [31:0] rt_val,
  input logic [31:0] next_pc,
  input logic        taken
);
  logic [31:0] pc4;
  logic        known;
  assign pc4   = cur_pc + 32'd4;
  assign known = !$isunknown({cur_pc, instr, rs_val, rt_val, next_pc, taken});

  always_comb begin
    if (known) begin
      if (!taken)
        assert_fallthrough_R8: assert (next_pc == pc4)
          else $error("fall-through address wrong");
      assert_aligned_R6: assert (next_pc[1:0] == cur_pc[1:0])
        else $error("next address lost word alignment");
      if (instr[31:26] == 6'd2)
        assert_jump_taken_R7: assert (taken && next_pc[31:28] == pc4[31:28])
          else $error("jump not taken or left its region");
      if (instr[31:26] == 6'd4)
        assert_eq_R1: assert (taken == (rs_val == rt_val))
          else $error("equal branch decision wrong");
      if (instr[31:26] == 6'd7 && rs_val == 32'd0)
        assert_gtz_zero_R4: assert (!taken)
          else $error("positive test taken on zero");
      if (instr[31:26] == 6'd1 && instr[20:17] != 4'd0)
        assert_regimm_other_R5: assert (!taken)
          else $error("unassigned selector taken");
    end
  end
endmodule

bind npc_unit npc_unit_chk u_chk (.*);

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic [31:0] cur_pc = '0, instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] next_pc;
  logic        taken;
  int          n_run = 0, n_fail = 0, cycles = 0;

  always #10 clk = ~clk;

  npc_unit u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // Reference model built from the requirement text.
  function automatic logic [32:0] model(input logic [31:0] pc, ins, a, b);
    logic [5:0]  op  = ins[31:26];
    logic [4:0]  sel = ins[20:16];
    int          sa  = int'(a);
    int          off = int'($signed(ins[15:0]));
    logic [31:0] pc4 = pc + 32'd4;
    logic        tk;
    case (op)
      6'd4: tk = (a == b);
      6'd5: tk = (a != b);
      6'd6: tk = (sa <= 0);
      6'd7: tk = (sa > 0);
      6'd1: tk = (sel == 5'd0) ? (sa < 0) : (sel == 5'd1) ? (sa >= 0) : 1'b0;
      6'd2: tk = 1'b1;
      default: tk = 1'b0;
    endcase
    if (op == 6'd2) return {1'b1, pc4[31:28], ins[25:0], 2'b00};
    if (tk) return {1'b1, pc4 + 32'(off * 4)};
    return {1'b0, pc4};
  endfunction

  task automatic apply(input string req, input logic [31:0] pc, ins, a, b);
    logic [32:0] exp;
    @(posedge clk);
    cur_pc = pc; instr = ins; rs_val = a; rt_val = b;
    @(negedge clk);
    exp = model(pc, ins, a, b);
    n_run = n_run + 1;
    if ({taken, next_pc} !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: op=%0d pc=%h rs=%h rt=%h actual=%b/%h expected=%b/%h",
               req, ins[31:26], pc, a, b, taken, next_pc, exp[32], exp[31:0]);
    end
  endtask

  logic [31:0] vals [7] = '{32'd0, 32'd1, 32'hFFFF_FFFF, 32'd5, 32'hFFFF_FFFB,
                            32'h7FFF_FFFF, 32'h8000_0000};
  logic [15:0] offs [5] = '{16'd0, 16'd3, 16'hFFFD, 16'h7FFF, 16'h8000};
  logic [31:0] pcs  [2] = '{32'h0040_0100, 32'h1FFF_FFFC};

  initial begin
    // reset-like idle state: all-zero inputs fall through
    apply("R8_idle", 32'd0, 32'd0, 32'd0, 32'd0);
    // R1 R2 equality pair, R6 target
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 5; o++)
        for (int i = 0; i < 7; i++)
          for (int j = 0; j < 7; j++) begin
            apply("R1/R6", pcs[p], {6'd4, 5'd3, 5'd4, offs[o]}, vals[i], vals[j]);
            apply("R2/R6", pcs[p], {6'd5, 5'd3, 5'd4, offs[o]}, vals[i], vals[j]);
          end
    // R3 R4 R5 zero tests; R9: rt_val swept and must not matter
    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 5; o++)
        for (int i = 0; i < 7; i++)
          for (int j = 0; j < 7; j += 3) begin
            apply("R3/R9", pcs[p], {6'd6, 5'd2, 5'd0, offs[o]}, vals[i], vals[j]);
            apply("R4/R9", pcs[p], {6'd7, 5'd2, 5'd0, offs[o]}, vals[i], vals[j]);
            apply("R5/R9", pcs[p], {6'd1, 5'd2, 5'd0, offs[o]}, vals[i], vals[j]);
            apply("R5/R9", pcs[p], {6'd1, 5'd2, 5'd1, offs[o]}, vals[i], vals[j]);
          end
    // R5 unassigned selector values
    for (int s = 2; s < 32; s++)
      for (int i = 0; i < 7; i++)
        apply("R5_sel", 32'h0040_0000, {6'd1, 5'd0, 5'(s), 16'h0010}, vals[i], 32'd0);
    // R7 jump, including region carry from pc+4
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 7; i++) begin
        apply("R7/R9", pcs[p], {6'd2, 26'h3FF_FFFF}, vals[i], vals[6-i]);
        apply("R7", pcs[p] ^ 32'hF000_0000, {6'd2, 26'(i * 32'h12345)}, vals[i], 32'd0);
      end
    apply("R7_wrap", 32'hFFFF_FFFC, {6'd2, 26'h000_0001}, 32'd0, 32'd0);
    // R8 every opcode that falls through
    for (int op = 0; op < 64; op++)
      if (!(op inside {1, 2, 4, 5, 6, 7}))
        for (int i = 0; i < 7; i += 2)
          apply("R8", 32'h0040_0200, {6'(op), 5'd0, 5'd0, 16'hFFFF}, vals[i], vals[i]);
    // R6 wrap-around of the address space
    apply("R6_wrap", 32'hFFFF_FFFC, {6'd4, 10'd0, 16'h0002}, 32'd0, 32'd0);
    apply("R6_wrap", 32'h0000_0000, {6'd5, 10'd0, 16'hFFF0}, 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule